// File: doc/BRIEF.md
# Masked-Write GPIO Port

A general-purpose I/O port that controls one pin per bit of a 32-bit register bus. Each pin has an output-enable bit and an output data latch. Synchronized samples of the pin inputs can be read back at any time. Software attaches the port to a simple single-cycle register port, and the pad ring takes the `pin_out` and `pin_oe` vectors.

Direction is never written as a whole word. One register turns pins into outputs, and a second register turns pins back into inputs. In both, a 1 bit acts on its pin and a 0 bit leaves the pin as it was. Output data is split into a low-pin half-word register and a high-pin half-word register. Each write to one of these carries a 16-bit mask in its upper half, so software can change individual pins with no read-modify-write. The expected sequence is to load the data value first and then enable the pin. The pin then drives the loaded value from the first cycle its enable is set.

Top module: `gpio_mw_port`

## Requirements
- R1: A write to offset 0x00 sets the output enable of every pin whose write-data bit is 1. Pins whose bit is 0 keep their enable.
- R2: A write to offset 0x04 clears the output enable of every pin whose write-data bit is 1. Pins whose bit is 0 keep their enable.
- R3: A read of offset 0x04 returns the 32-bit output-enable vector. Bit n belongs to pin n.
- R4: In a write to 0x08 or 0x0C, bits 31:16 are a mask and bits 15:0 are data. Data bit k is loaded only when mask bit k+16 is 1. Every other bit keeps its value.
- R5: Offset 0x08 holds the data for pins 15:0 and offset 0x0C holds the data for pins 31:16. A write to one half never changes the other half.
- R6: A read of offset 0x10 returns the pin inputs after a two-flop synchronizer. A level applied before clock edge e is first returned by a read whose data is captured at edge e+2.
- R7: `pin_out` always presents the data latches and `pin_oe` presents the enables, both straight from registers. A pin therefore drives its latched value in the same cycle its enable becomes 1.
- R8: After synchronous reset, all enables and all data latches are 0 and `reg_rdata` is 0.
- R9: A read of 0x08 or 0x0C returns the 16 data bits of that half in bits 15:0, with bits 31:16 zero. A read of any other offset, 0x00 included, returns 0. A write to 0x10 or to any unmapped offset changes neither the enables nor the data.
- R10: `reg_rdata` is registered. It updates on the clock edge where `reg_rd` is high and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (8) | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Raw pin input levels |
| pin_out | output | 32 | Output data per pin |
| pin_oe | output | 32 | Output enable per pin |

## Verification
Six masked half-word writes are applied in sequence: full-mask loads, a partial mask, an all-zero mask with busy data, a clearing mask on the high half, and a sparse mask with mixed data. Together they separate masked-bit loading from kept bits and low-half decoding from high-half decoding. The direction tests overlap set and clear writes on the same pins, which shows whether 0 bits are truly left alone. Input reads taken one cycle early and then on time confirm the two-stage synchronizer latency. Writes to the read-only and unmapped offsets, with all-ones data, show that they leave every pin as it was.

// File: rtl/gpio_mw_pkg.sv
package gpio_mw_pkg;
  // Byte offsets of the register map (eight-bit form, resized by users)
  localparam logic [7:0] OFF_OE_SET = 8'h00;
  localparam logic [7:0] OFF_OE_CLR = 8'h04;
  localparam logic [7:0] OFF_DO_LO  = 8'h08;
  localparam logic [7:0] OFF_DO_HI  = 8'h0C;
  localparam logic [7:0] OFF_PIN_IN = 8'h10;
endpackage

// File: rtl/gpio_mw_sync.sv
module gpio_mw_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_mw_dir.sv
module gpio_mw_dir #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] bits,
  output logic [WIDTH-1:0] oe_q
);
  always_ff @(posedge clk) begin
    if (rst)         oe_q <= '0;
    else if (set_we) oe_q <= oe_q | bits;
    else if (clr_we) oe_q <= oe_q & ~bits;
  end

  p_oe_set_r1: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((oe_q & $past(bits)) == $past(bits)));
  p_oe_clr_r2: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((oe_q & $past(bits)) == '0));
  p_oe_keep_r1: assert property (@(posedge clk) disable iff (rst)
    (set_we || clr_we) |=> (((oe_q ^ $past(oe_q)) & ~$past(bits)) == '0));
  p_oe_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !(set_we || clr_we) |=> $stable(oe_q));
endmodule

// File: rtl/gpio_mw_half.sv
module gpio_mw_half #(
  parameter int REG_W = 32,
  localparam int HALF = REG_W / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [HALF-1:0]  dout_q
);
  logic [HALF-1:0] mask;
  logic [HALF-1:0] data;

  assign mask = wdata[REG_W-1:HALF];
  assign data = wdata[HALF-1:0];

  always_ff @(posedge clk) begin
    if (rst)     dout_q <= '0;
    else if (we) dout_q <= (dout_q & ~mask) | (data & mask);
  end

  p_mask_keep_r4: assert property (@(posedge clk) disable iff (rst)
    we |=> (((dout_q ^ $past(dout_q)) & ~$past(mask)) == '0));
  p_mask_load_r4: assert property (@(posedge clk) disable iff (rst)
    we |=> (((dout_q ^ $past(data)) & $past(mask)) == '0));
  p_half_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(dout_q));
endmodule

// File: rtl/gpio_mw_port.sv
module gpio_mw_port
  import gpio_mw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int REG_W  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [REG_W-1:0]  pin_in,
  output logic [REG_W-1:0]  pin_out,
  output logic [REG_W-1:0]  pin_oe
);
  localparam int NPINS = REG_W;
  localparam int HALF  = REG_W / 2;

  logic hit_set, hit_clr, hit_lo, hit_hi, hit_in;
  assign hit_set = (reg_addr == ADDR_W'(OFF_OE_SET));
  assign hit_clr = (reg_addr == ADDR_W'(OFF_OE_CLR));
  assign hit_lo  = (reg_addr == ADDR_W'(OFF_DO_LO));
  assign hit_hi  = (reg_addr == ADDR_W'(OFF_DO_HI));
  assign hit_in  = (reg_addr == ADDR_W'(OFF_PIN_IN));

  logic [NPINS-1:0] oe_q;
  logic [NPINS-1:0] in_sync;
  logic [HALF-1:0]  half_q [2];

  gpio_mw_dir #(.WIDTH(NPINS)) u_dir (
    .clk    (clk),
    .rst    (rst),
    .set_we (reg_wr && hit_set),
    .clr_we (reg_wr && hit_clr),
    .bits   (reg_wdata),
    .oe_q   (oe_q)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic sel;
    assign sel = (h == 0) ? hit_lo : hit_hi;
    gpio_mw_half #(.REG_W(REG_W)) u_half (
      .clk    (clk),
      .rst    (rst),
      .we     (reg_wr && sel),
      .wdata  (reg_wdata),
      .dout_q (half_q[h])
    );
  end

  gpio_mw_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (in_sync)
  );

  logic [REG_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_clr)     rd_mux = oe_q;
    else if (hit_lo) rd_mux = {{(REG_W-HALF){1'b0}}, half_q[0]};
    else if (hit_hi) rd_mux = {{(REG_W-HALF){1'b0}}, half_q[1]};
    else if (hit_in) rd_mux = in_sync;
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assign pin_out = {half_q[1], half_q[0]};
  assign pin_oe  = oe_q;

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
  p_half_upper_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && (hit_lo || hit_hi)) |=> (reg_rdata[REG_W-1:HALF] == '0));
  p_oe_read_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && hit_clr && !reg_wr) |=> (reg_rdata == pin_oe));
endmodule

// File: tb/gpio_mw_port_bench.sv
module gpio_mw_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  gpio_mw_port u_gpio_mw_port (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  localparam int NV = 6;
  localparam logic [7:0]  T_ADDR [NV] = '{8'h08, 8'h0C, 8'h08, 8'h0C, 8'h0C, 8'h08};
  localparam logic [31:0] T_DATA [NV] = '{32'hFFFF_A5A5, 32'hFFFF_1234, 32'h00F0_FFFF,
                                          32'h0000_FFFF, 32'hF00F_0000, 32'h0101_0100};
  localparam logic [31:0] T_EXP  [NV] = '{32'h0000_A5A5, 32'h1234_A5A5, 32'h1234_A5F5,
                                          32'h1234_A5F5, 32'h0230_A5F5, 32'h0230_A5F4};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8 reset state
    check("R8 pin_oe", pin_oe, 32'h0);
    check("R8 pin_out", pin_out, 32'h0);
    check("R8 rdata", reg_rdata, 32'h0);

    // R4 R5 masked half-word writes from the vector table
    for (int i = 0; i < NV; i++) begin
      wr(T_ADDR[i], T_DATA[i]);
      check("R4 R5 pin_out after masked write", pin_out, T_EXP[i]);
    end
    rd(8'h08, v); check("R9 read low half", v, 32'h0000_A5F4);
    rd(8'h0C, v); check("R9 read high half", v, 32'h0000_0230);

    // R1 R2 R3 direction
    wr(8'h00, 32'h0000_00FF);
    check("R1 set low byte", pin_oe, 32'h0000_00FF);
    // R7 enabled pins drive latched data at once
    check("R7 pin_out with oe", pin_out, 32'h0230_A5F4);
    wr(8'h00, 32'h0F00_0000);
    check("R1 zeros keep", pin_oe, 32'h0F00_00FF);
    wr(8'h04, 32'h0000_000F);
    check("R2 clear nibble", pin_oe, 32'h0F00_00F0);
    rd(8'h04, v); check("R3 read oe", v, 32'h0F00_00F0);
    rd(8'h00, v); check("R9 read set reg zero", v, 32'h0);

    // R9 writes to read-only and unmapped offsets ignored
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    check("R9 oe unchanged", pin_oe, 32'h0F00_00F0);
    check("R9 out unchanged", pin_out, 32'h0230_A5F4);
    rd(8'h20, v); check("R9 unmapped read", v, 32'h0);

    // R6 synchronizer latency
    @(negedge clk);
    pin_in = 32'hCAFE_0042;
    reg_rd = 1'b1; reg_addr = 8'h10;
    @(negedge clk);
    check("R6 early read old", reg_rdata, 32'h0);
    @(negedge clk);
    check("R6 second read old", reg_rdata, 32'h0);
    @(negedge clk);
    reg_rd = 1'b0;
    check("R6 third read new", reg_rdata, 32'hCAFE_0042);

    // R10 hold while no read
    pin_in = 32'h1111_1111;
    repeat (4) @(negedge clk);
    check("R10 rdata holds", reg_rdata, 32'hCAFE_0042);

    // R8 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R8 oe after reset", pin_oe, 32'h0);
    check("R8 out after reset", pin_out, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule